// File: doc/BRIEF.md
# Strobe-Controlled FIFO with Early Boundary Flags

This block is a first-in first-out buffer nine bits wide. Its depth is a parameter. It is run by two active-low strobes, one for reading and one for writing, and has no enable or valid inputs. A fast system clock passes each strobe through a two-flop synchronizer and then detects its falling and rising edges. A write stores the data input when its strobe rises. A read puts the oldest word on a tri-state data output while its strobe is low, and it frees that word when the strobe rises.

The two flags are active low. The empty flag goes low as soon as the last stored word begins to be read. The full flag goes low as soon as the write that fills the last slot begins. Each flag then stays low until the opposite strobe rises and completes an operation. A read strobe that begins while the buffer is empty is ignored, and so is a write strobe that begins while it is full. Neither one moves a pointer or changes the occupancy count. A synchronous active-high reset clears the buffer.

Top module: `strobe_fifo`

## Requirements
- R1: While `rst` is high and on the cycle after it, `empty_n` is 0 and `full_n` is 1. `dout_en` is 0 and the buffer holds no words.
- R2: The design acts on a level change of `rd_n` or `wr_n` at the third rising clock edge that samples the new level, not earlier. The synchronizer has two stages.
- R3: A read strobe that falls while the buffer holds at least one word raises `dout_en` and drives `dout` with the oldest word. The output stays driven until the strobe rises. Only that rising edge removes the word.
- R4: If the buffer holds exactly one word when a read strobe falls, `empty_n` goes to 0 at that falling edge, while the read is still in progress.
- R5: A read strobe that falls while the buffer is empty is ignored. `dout_en` stays 0 and no word is removed, so the next written word is the next word read.
- R6: A low `empty_n` returns to 1 only when a write strobe rises and completes a write. The falling edge of the write strobe does not release it.
- R7: A write stores the value on `din` as seen when `wr_n` rises. Words are read out in the order they were written.
- R8: If the buffer holds DEPTH-1 words when a write strobe falls, `full_n` goes to 0 at that falling edge. The two flags are never low at the same time.
- R9: A write strobe that falls while the buffer is full is discarded. `full_n` stays 0 and the stored words are unchanged.
- R10: A low `full_n` returns to 1 only when a read strobe rises and completes a read.
- R11: If a read and a write complete on the same clock edge, the occupancy count is unchanged.
- R12: When no accepted read is in progress, `dout_en` is 0 and `dout` is high impedance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the strobes |
| rst | input | 1 | Synchronous active-high master reset |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| din | input | 9 | Write data, held stable around the rising edge of `wr_n` |
| dout | output | 9 | Read data; high impedance when no read is in progress |
| dout_en | output | 1 | High while `dout` is driven |
| empty_n | output | 1 | Active-low empty flag |
| full_n | output | 1 | Active-low full flag |

## Verification
The bench builds the block with a depth of 8 and keeps the default two synchronizer stages. With depth 8 the full boundary is reached after a handful of strobes. This puts the early full flag, the discarded writes and the release of the full flag by a read within a short run. Pointer wrap-around is also exercised more than once. With the default synchronizer the bench can pin the three-edge reaction time exactly and sample the flags between the falling and rising edges of one strobe.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;

    localparam int unsigned WORD_W = 9;

    // Edge events recovered from one synchronized active-low strobe
    typedef struct packed {
        logic fall;
        logic rise;
    } strobe_edge_t;

    // Per-side cycle state: idle, or an accepted strobe awaiting its rising edge
    typedef enum logic {
        SIDE_IDLE = 1'b0,
        SIDE_LIVE = 1'b1
    } side_state_t;

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync
    import strobe_fifo_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         strobe_n,
    output strobe_edge_t ev
);
    logic [STAGES-1:0] chain;
    logic              prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= strobe_n;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b1;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= chain[STAGES-1];
    end

    always_comb begin
        ev.fall = prev_q & ~chain[STAGES-1];
        ev.rise = ~prev_q & chain[STAGES-1];
    end
endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
    import strobe_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 512,
    parameter int unsigned PTR_W = 9,
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  strobe_edge_t     rd_ev,
    input  strobe_edge_t     wr_ev,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [CNT_W-1:0] count,
    output logic             rd_take,
    output logic             rd_done,
    output logic             wr_done,
    output logic             rd_live,
    output logic             empty_n,
    output logic             full_n
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    side_state_t rd_state, wr_state;
    logic        wr_live, wr_take;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    assign rd_live = (rd_state == SIDE_LIVE);
    assign wr_live = (wr_state == SIDE_LIVE);

    // Falling edges are accepted only away from the boundary
    assign rd_take = rd_ev.fall && !rd_live && (count != '0);
    assign wr_take = wr_ev.fall && !wr_live && (count != CNT_FULL);
    // Rising edges complete only an accepted cycle
    assign rd_done = rd_ev.rise && rd_live;
    assign wr_done = wr_ev.rise && wr_live;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_state <= SIDE_IDLE;
            wr_state <= SIDE_IDLE;
            rd_ptr   <= '0;
            wr_ptr   <= '0;
            count    <= '0;
        end else begin
            if (rd_take)      rd_state <= SIDE_LIVE;
            else if (rd_done) rd_state <= SIDE_IDLE;
            if (wr_take)      wr_state <= SIDE_LIVE;
            else if (wr_done) wr_state <= SIDE_IDLE;
            if (rd_done) rd_ptr <= step(rd_ptr);
            if (wr_done) wr_ptr <= step(wr_ptr);
            count <= count + CNT_W'(wr_done) - CNT_W'(rd_done);
        end
    end

    // Flags look ahead by the cycle in progress on each side
    assign empty_n = (count != CNT_W'(rd_live));
    assign full_n  = ((count + CNT_W'(wr_live)) != CNT_FULL);
endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
    parameter int unsigned DEPTH  = 512,
    parameter int unsigned DATA_W = 9,
    parameter int unsigned PTR_W  = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
    import strobe_fifo_pkg::*;
#(
    parameter int unsigned DEPTH       = 512,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout,
    output logic              dout_en,
    output logic              empty_n,
    output logic              full_n
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    strobe_edge_t      rd_ev, wr_ev;
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic [CNT_W-1:0]  count;
    logic              rd_take, rd_done, wr_done, rd_live;
    logic [WORD_W-1:0] rdata;

    strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
        .clk(clk), .rst(rst), .strobe_n(rd_n), .ev(rd_ev)
    );

    strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk(clk), .rst(rst), .strobe_n(wr_n), .ev(wr_ev)
    );

    fifo_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst(rst), .rd_ev(rd_ev), .wr_ev(wr_ev),
        .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .count(count),
        .rd_take(rd_take), .rd_done(rd_done), .wr_done(wr_done),
        .rd_live(rd_live), .empty_n(empty_n), .full_n(full_n)
    );

    fifo_store #(.DEPTH(DEPTH), .DATA_W(WORD_W), .PTR_W(PTR_W)) u_store (
        .clk(clk), .we(wr_done), .waddr(wr_ptr), .wdata(din),
        .re(rd_take), .raddr(rd_ptr), .rdata(rdata)
    );

    assign dout_en = rd_live;
    assign dout    = rd_live ? rdata : {WORD_W{1'bz}};
endmodule

// File: rtl/strobe_fifo_checker.sv
module strobe_fifo_checker #(
    parameter int unsigned DEPTH = 512,
    parameter int unsigned CNT_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             empty_n,
    input logic             full_n,
    input logic             dout_en,
    input logic [CNT_W-1:0] count,
    input logic             rd_done,
    input logic             wr_done
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!empty_n && full_n && !dout_en && count == '0));

    assert_read_needs_word_R5: assert property (@(posedge clk) disable iff (rst)
        dout_en |-> (count != '0));

    assert_empty_held_R6: assert property (@(posedge clk) disable iff (rst)
        (!empty_n && !wr_done) |=> !empty_n);

    assert_flags_disjoint_R8: assert property (@(posedge clk) disable iff (rst)
        !(!empty_n && !full_n));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    assert_full_held_R10: assert property (@(posedge clk) disable iff (rst)
        (!full_n && !rd_done) |=> !full_n);

    assert_balanced_count_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_done && wr_done) |=> $stable(count));
endmodule

bind strobe_fifo strobe_fifo_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .empty_n(empty_n), .full_n(full_n),
    .dout_en(dout_en), .count(count), .rd_done(rd_done), .wr_done(wr_done)
);

// File: tb/strobe_fifo_bench.sv
module strobe_fifo_bench;
    localparam int DEPTH = 8;
    localparam int LOW_CY = 4;
    localparam int HIGH_CY = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [8:0] din = '0;
    wire  [8:0] dout;
    wire        dout_en, empty_n, full_n;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    strobe_fifo #(.DEPTH(DEPTH), .SYNC_STAGES(2)) u_strobe_fifo (
        .clk(clk), .rst(rst), .rd_n(rd_n), .wr_n(wr_n), .din(din),
        .dout(dout), .dout_en(dout_en), .empty_n(empty_n), .full_n(full_n)
    );

    // Behavioural reference: strobe history plus a word queue
    logic [8:0] q[$];
    logic [8:0] m_rd_val = '0;
    bit m_rd_act = 0, m_wr_act = 0;
    bit rd_h1 = 1, rd_h2 = 1, rd_h3 = 1, rd_h4 = 1;
    bit wr_h1 = 1, wr_h2 = 1, wr_h3 = 1, wr_h4 = 1;

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            m_rd_act = 0; m_wr_act = 0;
            rd_h1 = 1; rd_h2 = 1; rd_h3 = 1; rd_h4 = 1;
            wr_h1 = 1; wr_h2 = 1; wr_h3 = 1; wr_h4 = 1;
        end else begin
            bit rf, rr, wf, wrr, take_r, take_w, done_r, done_w;
            int n0;
            rd_h4 = rd_h3; rd_h3 = rd_h2; rd_h2 = rd_h1; rd_h1 = rd_n;
            wr_h4 = wr_h3; wr_h3 = wr_h2; wr_h2 = wr_h1; wr_h1 = wr_n;
            rf  = (rd_h4 && !rd_h3);
            rr  = (!rd_h4 && rd_h3);
            wf  = (wr_h4 && !wr_h3);
            wrr = (!wr_h4 && wr_h3);
            n0 = q.size();
            take_r = rf && !m_rd_act && (n0 != 0);
            take_w = wf && !m_wr_act && (n0 != DEPTH);
            done_r = rr && m_rd_act;
            done_w = wrr && m_wr_act;
            if (take_r) begin m_rd_act = 1; m_rd_val = q[0]; end
            if (done_r) begin void'(q.pop_front()); m_rd_act = 0; end
            if (done_w) begin q.push_back(din); m_wr_act = 0; end
            if (take_w) m_wr_act = 1;
        end
    end

    task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check("R4/R6 empty_n vs model", {8'd0, empty_n},
                  {8'd0, !(q.size() == int'(m_rd_act))});
            check("R8/R9/R10 full_n vs model", {8'd0, full_n},
                  {8'd0, !(q.size() + int'(m_wr_act) == DEPTH)});
            check("R12 dout_en vs model", {8'd0, dout_en}, {8'd0, m_rd_act});
            if (m_rd_act) check("R3/R7 dout vs model", dout, m_rd_val);
        end
    end

    task automatic strobe(input bit do_rd, input bit do_wr, input logic [8:0] d);
        @(negedge clk);
        din = d;
        if (do_rd) rd_n = 1'b0;
        if (do_wr) wr_n = 1'b0;
        repeat (LOW_CY) @(negedge clk);
        rd_n = 1'b1; wr_n = 1'b1;
        repeat (HIGH_CY) @(negedge clk);
    endtask

    task automatic settle(input int edges);
        repeat (edges) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 empty_n at reset", {8'd0, empty_n}, 9'd0);
        check("R1 full_n at reset", {8'd0, full_n}, 9'd1);
        check("R1 dout_en at reset", {8'd0, dout_en}, 9'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 empty_n after reset", {8'd0, empty_n}, 9'd0);

        // R5: reads on an empty buffer are ignored
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); rd_n = 1'b0;
            settle(3);
            check("R5 dout_en on empty read", {8'd0, dout_en}, 9'd0);
            rd_n = 1'b1;
            repeat (HIGH_CY) @(negedge clk);
        end
        strobe(0, 1, 9'h0A5);
        strobe(1, 0, 9'h000);
        check("R5 empty after one write and one read", {8'd0, empty_n}, 9'd0);

        // R2 latency and R4 early empty on last word
        strobe(0, 1, 9'h13C);
        rd_n = 1'b0;
        settle(2);
        check("R2 no reaction after two edges", {8'd0, empty_n}, 9'd1);
        settle(1);
        check("R4 empty at fall of last read", {8'd0, empty_n}, 9'd0);
        check("R3 dout holds oldest word", dout, 9'h13C);
        check("R3 dout_en during read", {8'd0, dout_en}, 9'd1);
        // R6: write during last read; only its rise releases empty
        wr_n = 1'b0; din = 9'h0F0;
        settle(3);
        check("R6 empty kept after write fall", {8'd0, empty_n}, 9'd0);
        wr_n = 1'b1;
        settle(3);
        check("R6 empty released by write rise", {8'd0, empty_n}, 9'd1);
        rd_n = 1'b1;
        settle(3);
        check("R12 dout_en off after read rise", {8'd0, dout_en}, 9'd0);
        strobe(1, 0, 9'h000);

        // R8: fill; the last write flags full at its fall
        for (int i = 0; i < DEPTH - 1; i++) strobe(0, 1, 9'(9'h100 + i));
        @(negedge clk); wr_n = 1'b0; din = 9'h1AB;
        settle(3);
        check("R8 full at fall of last write", {8'd0, full_n}, 9'd0);
        wr_n = 1'b1;
        repeat (HIGH_CY) @(negedge clk);
        // R9: writes on a full buffer are discarded
        for (int i = 0; i < 3; i++) strobe(0, 1, 9'h1FF);
        check("R9 full held after extra writes", {8'd0, full_n}, 9'd0);
        // R10: read fall keeps full; read rise releases it
        @(negedge clk); rd_n = 1'b0;
        settle(3);
        check("R10 full kept after read fall", {8'd0, full_n}, 9'd0);
        check("R7 first stored word read first", dout, 9'h100);
        rd_n = 1'b1;
        settle(3);
        check("R10 full released by read rise", {8'd0, full_n}, 9'd1);
        for (int i = 1; i < DEPTH; i++) strobe(1, 0, 9'h000);
        check("R9 drained to empty, last word 1AB", {8'd0, empty_n}, 9'd0);

        // R11: simultaneous read and write keep the count
        for (int i = 0; i < 3; i++) strobe(0, 1, 9'(9'h040 + i));
        for (int i = 0; i < 4; i++) strobe(1, 1, 9'(9'h080 + i));
        for (int i = 0; i < 3; i++) strobe(1, 0, 9'h000);
        check("R11 three words after balanced strobes", {8'd0, empty_n}, 9'd0);
        @(negedge clk); rd_n = 1'b0;
        settle(3);
        check("R11 fourth read finds empty", {8'd0, dout_en}, 9'd0);
        rd_n = 1'b1;
        repeat (HIGH_CY) @(negedge clk);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule